// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Burst SRAM

A synchronous single-port memory whose address and control are registered on the rising clock edge and whose data path is pipelined. Read data comes out and write data goes in at the same depth in the pipeline. Because of that alignment, read, write and deselect cycles can follow one another on every clock with no idle turnaround cycle between them.

A 2-bit burst counter generates the next three addresses of a four-word block after a load. The counter follows a linear or an interleaved order, chosen when the burst is loaded. Each 36-bit word is split into four 9-bit byte lanes, and each lane has its own write enable. Three chip selects decode the device for depth expansion.

An active-low clock enable freezes the whole pipeline. A sleep input ignores all inputs and blanks the output while keeping the contents. An asynchronous output enable gates the read data. The data bus is modelled as separate write-data and read-data ports plus an output-valid flag.

Top module: `zbt_sram`

## Requirements
- R1: After reset, rvalid_o is low, rdata_o is zero and no operation is in flight.
- R2: A read loaded at enabled edge E0 drives rvalid_o high and rdata_o with the word after enabled edge E2. The valid flag drops at the next enabled edge unless a later read lands there.
- R3: Write data is sampled from wdata_i at the second enabled edge after the write's load edge. Reads and writes may alternate on every cycle with no idle cycle, and a read issued after a write to the same address returns the new data.
- R4: be_ni[i] low enables byte lane i, which is wdata_i bits [9i+8:9i]. Byte enables are sampled on every command cycle, load or continue. A write with all four byte enables high is an abort and leaves the memory unchanged.
- R5: With adv_i high, the previous operation type continues at the next burst address, and the address bits above bit 1 stay fixed. On such a cycle, addr_i, we_ni and the chip selects are ignored.
- R6: If burst_ilv_i is low at the load cycle, the n-th word of the burst (n = 0..3) uses low offset (start + n) mod 4, where start is addr_i[1:0].
- R7: If burst_ilv_i is high at the load cycle, the n-th word uses offset start XOR n. The mode value sampled at the load cycle governs the whole burst.
- R8: A load cycle selects the device only when cs1_ni is low, cs2_i is high and cs3_ni is low. Any other combination loads a deselect: nothing is written and no read data appears. Continuing a deselect stays deselected.
- R9: While clk_en_ni is high, every pipeline register holds, including rdata_o and rvalid_o, and all synchronous inputs are ignored.
- R10: While sleep_i is high, synchronous inputs are ignored, the pipeline holds, memory is retained, and rvalid_o is low with rdata_o zero.
- R11: oe_ni high forces rvalid_o low and rdata_o to zero without waiting for a clock edge, and leaves the pipeline untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_ni | input | 1 | Clock enable, active low; high freezes the pipeline |
| cs1_ni | input | 1 | Chip select, active low |
| cs2_i | input | 1 | Chip select, active high |
| cs3_ni | input | 1 | Chip select, active low |
| adv_i | input | 1 | High: continue burst; low: load new command |
| we_ni | input | 1 | Low: write, high: read (load cycles) |
| be_ni | input | LANES | Byte lane write enables, active low |
| burst_ilv_i | input | 1 | High: interleaved burst order, low: linear |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep: inputs ignored, output blanked |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Read data, zero when not valid |
| rvalid_o | output | 1 | Read data valid |

## Verification
The bench alternates writes and reads on consecutive cycles. A design that sampled write data one cycle early or late would store the neighbouring command's bus value, and the following read would expose it. Bursts are started at offsets where linear and interleaved orders differ, and the mode is toggled after the load. A swapped order, a live rather than latched mode, or a carry into the upper address bits therefore returns words from the wrong slots. Clock-enable and sleep tests issue write commands while the pipeline is frozen and hold a valid read across the freeze. A design that leaked a command through, or lost or duplicated the read, would show a changed word or a wrong valid flag. Deselect tests try each failing chip-select combination with a write and with a read-then-continue, which catches partial select decoding.

// File: rtl/zbt_pkg.sv
package zbt_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;

  // low address offset of beat cnt of a burst starting at base
  function automatic logic [1:0] burst_offs(logic [1:0] base, logic [1:0] cnt, logic ilv);
    return ilv ? (base ^ cnt) : (base + cnt);
  endfunction

endpackage

// File: rtl/zbt_burst_ctr.sv
module zbt_burst_ctr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic              ilv_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  import zbt_pkg::*;

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q;
  logic [1:0]      base_q;
  logic [1:0]      cnt_q;
  logic            ilv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      ilv_q  <= 1'b0;
    end else if (en_i) begin
      if (load_i) begin
        hi_q   <= addr_i[ADDR_W-1:2];
        base_q <= addr_i[1:0];
        cnt_q  <= '0;
        ilv_q  <= ilv_i;
      end else begin
        cnt_q  <= cnt_q + 2'd1;
      end
    end
  end

  assign addr_o = {hi_q, burst_offs(base_q, cnt_q, ilv_q)};

endmodule

// File: rtl/zbt_byte_ram.sv
module zbt_byte_ram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    en_i,
  input  logic                    wr_i,
  input  logic                    rd_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        be_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk_i) begin
      if (en_i && wr_i && be_i[l]) mem[addr_i] <= wdata_i[l*LANE_W +: LANE_W];
      if (en_i && rd_i)            rd_q        <= mem[addr_i];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = rd_q;
  end

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clk_en_ni,
  input  logic                    cs1_ni,
  input  logic                    cs2_i,
  input  logic                    cs3_ni,
  input  logic                    adv_i,
  input  logic                    we_ni,
  input  logic [LANES-1:0]        be_ni,
  input  logic                    burst_ilv_i,
  input  logic                    oe_ni,
  input  logic                    sleep_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvalid_o
);
  import zbt_pkg::*;

  localparam int DATA_W = LANES * LANE_W;

  logic              en, sel, load;
  op_e               a_op, b_op;
  logic [LANES-1:0]  a_be, b_be;
  logic [ADDR_W-1:0] a_addr, b_addr;
  logic              rvld_q;
  logic [DATA_W-1:0] rd_q;

  assign en   = ~clk_en_ni & ~sleep_i;
  assign sel  = ~cs1_ni & cs2_i & ~cs3_ni;
  assign load = ~adv_i;

  // stage A: command capture; on continue the op type is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_op <= OP_IDLE;
      a_be <= '0;
    end else if (en) begin
      if (load) a_op <= !sel ? OP_IDLE : (we_ni ? OP_RD : OP_WR);
      a_be <= ~be_ni;
    end
  end

  zbt_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .load_i (load),
    .ilv_i  (burst_ilv_i),
    .addr_i (addr_i),
    .addr_o (a_addr)
  );

  // stage B: delay so write data lines up with read data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_op   <= OP_IDLE;
      b_be   <= '0;
      b_addr <= '0;
      rvld_q <= 1'b0;
    end else if (en) begin
      b_op   <= a_op;
      b_be   <= a_be;
      b_addr <= a_addr;
      rvld_q <= (b_op == OP_RD);
    end
  end

  zbt_byte_ram #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_ram (
    .clk_i   (clk_i),
    .en_i    (en),
    .wr_i    (b_op == OP_WR),
    .rd_i    (b_op == OP_RD),
    .addr_i  (b_addr),
    .be_i    (b_be),
    .wdata_i (wdata_i),
    .rdata_o (rd_q)
  );

  assign rvalid_o = rvld_q & ~oe_ni & ~sleep_i;
  assign rdata_o  = rvalid_o ? rd_q : '0;

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clk_en_ni,
  input logic              sleep_i,
  input logic              adv_i,
  input logic              cs1_ni,
  input logic              cs2_i,
  input logic              cs3_ni,
  input logic              oe_ni,
  input logic              rvalid_o,
  input zbt_pkg::op_e      a_op,
  input zbt_pkg::op_e      b_op,
  input logic              rvld_q,
  input logic [ADDR_W-1:0] a_addr
);
  import zbt_pkg::*;

  logic en_c, sel_c;
  assign en_c  = !clk_en_ni && !sleep_i;
  assign sel_c = !cs1_ni && cs2_i && !cs3_ni;

  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_c && b_op == OP_RD) |=> rvld_q);

  a_r5_continue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_c && adv_i) |=> (a_op == $past(a_op)) && (a_addr[ADDR_W-1:2] == $past(a_addr[ADDR_W-1:2])));

  a_r8_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_c && !adv_i && !sel_c) |=> a_op == OP_IDLE);

  a_r9_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_ni |=> $stable(a_op) && $stable(b_op) && $stable(rvld_q) && $stable(a_addr));

  a_r10_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !rvalid_o);

  a_r11_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !rvalid_o);

endmodule

bind zbt_sram zbt_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .clk_en_ni (clk_en_ni),
  .sleep_i   (sleep_i),
  .adv_i     (adv_i),
  .cs1_ni    (cs1_ni),
  .cs2_i     (cs2_i),
  .cs3_ni    (cs3_ni),
  .oe_ni     (oe_ni),
  .rvalid_o  (rvalid_o),
  .a_op      (a_op),
  .b_op      (b_op),
  .rvld_q    (rvld_q),
  .a_addr    (a_addr)
);

// File: tb/tb_zbt_sram.sv
`timescale 1ns/1ps
module tb_zbt_sram;
  localparam int AW = 6;
  localparam int DW = 36;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cke_n, cs1_n, cs2, cs3_n, adv, we_n, ilv, oe_n, slp;
  logic [3:0]    be_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          rvalid;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  zbt_sram #(.ADDR_W(AW), .LANES(4), .LANE_W(9)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_ni(cke_n), .cs1_ni(cs1_n), .cs2_i(cs2),
    .cs3_ni(cs3_n), .adv_i(adv), .we_ni(we_n), .be_ni(be_n), .burst_ilv_i(ilv),
    .oe_ni(oe_n), .sleep_i(slp), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid)
  );

  function automatic logic [DW-1:0] pat(int i);
    return (DW'(i) * 36'h0_1357_9BDF) ^ 36'hA_5A5A_5A5A;
  endfunction

  function automatic logic [1:0] offs(logic [1:0] s, int n, logic il);
    logic [1:0] nn = 2'(n);
    return il ? (s ^ nn) : 2'((int'(s) + n) % 4);
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask
  task automatic set_sel(); cs1_n = 0; cs2 = 1; cs3_n = 0; endtask
  task automatic ld(input logic wr, input logic [3:0] bn, input logic [AW-1:0] a);
    set_sel(); adv = 0; we_n = ~wr; be_n = bn; addr = a;
  endtask
  task automatic nop(); cs1_n = 1; cs2 = 1; cs3_n = 0; adv = 0; we_n = 1; be_n = '1; endtask
  // continue beat with junk on the ignored inputs
  task automatic cont(input logic [3:0] bn, input logic junk_we);
    adv = 1; be_n = bn; cs1_n = 1; cs2 = 0; we_n = junk_we; addr = '1;
  endtask

  task automatic wr1(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [3:0] bn);
    ld(1, bn, a); tick(); nop(); tick(); wdata = d; tick(); wdata = '1;
  endtask

  task automatic rd1(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic v);
    ld(0, 4'hF, a); tick(); nop(); tick(); tick(); d = rdata; v = rvalid;
  endtask

  task automatic t_reset();
    chk("R1 rvalid after reset", DW'(rvalid), '0);
    chk("R1 rdata after reset", rdata, '0);
  endtask

  task automatic t_latency();
    logic [DW-1:0] d; logic v;
    wr1(6'd2, pat(2), 4'h0);
    ld(0, 4'hF, 6'd2); tick(); nop(); tick();
    chk("R2 not valid after E1", DW'(rvalid), '0);
    tick();
    chk("R2 valid after E2", DW'(rvalid), 1);
    chk("R2 data after E2", rdata, pat(2));
    tick();
    chk("R2 valid drops after E3", DW'(rvalid), '0);
    rd1(6'd2, d, v);
    chk("R2 repeat read", d, pat(2));
  endtask

  task automatic t_turnaround();
    logic [DW-1:0] d; logic v;
    wr1(6'd9, pat(9), 4'h0);
    ld(1, 4'h0, 6'd8); tick();
    ld(0, 4'hF, 6'd9); tick();
    ld(1, 4'h0, 6'd10); wdata = pat(108); tick();
    chk("R3 no valid for write", DW'(rvalid), '0);
    ld(0, 4'hF, 6'd8); wdata = '0; tick();
    chk("R3 read between writes valid", DW'(rvalid), 1);
    chk("R3 read between writes data", rdata, pat(9));
    nop(); wdata = pat(110); tick();
    chk("R3 no valid for second write", DW'(rvalid), '0);
    nop(); wdata = '1; tick();
    chk("R3 read-after-write data", rdata, pat(108));
    rd1(6'd10, d, v);
    chk("R3 late write data", d, pat(110));
  endtask

  task automatic t_bytes();
    logic [DW-1:0] d, e; logic v;
    wr1(6'd32, '1, 4'h0);
    wr1(6'd32, '0, 4'b1010);
    e = '1;
    for (int l = 0; l < 4; l++) if (l == 0 || l == 2) e[l*9 +: 9] = '0;
    rd1(6'd32, d, v);
    chk("R4 lanes 0,2 written", d, e);
    wr1(6'd32, '0, 4'hF);
    rd1(6'd32, d, v);
    chk("R4 write abort no change", d, e);
  endtask

  task automatic burst_rd(string tag, logic [AW-1:0] blk, logic [1:0] st,
                          logic il_ld, logic il_after);
    for (int i = 0; i < 4; i++) wr1(blk + AW'(i), pat(int'(blk) + i), 4'h0);
    ilv = il_ld;
    for (int k = 0; k < 6; k++) begin
      if (k == 0) ld(0, 4'hF, blk + AW'(st));
      else if (k < 4) begin cont(4'hF, 1'b0); ilv = il_after; end
      else nop();
      tick();
      if (k >= 2) begin
        chk(tag, rdata, pat(int'(blk) + int'(offs(st, k - 2, il_ld))));
        chk(tag, DW'(rvalid), 1);
      end
    end
    ilv = 0;
  endtask

  task automatic burst_wr(string tag, logic [AW-1:0] blk, logic [1:0] st, logic il, int seed);
    logic [DW-1:0] d; logic v;
    ilv = il;
    for (int k = 0; k < 6; k++) begin
      if (k == 0) ld(1, 4'h0, blk + AW'(st));
      else if (k < 4) cont(4'h0, 1'b1);
      else nop();
      wdata = (k >= 2) ? pat(seed + k - 2) : '1;
      tick();
    end
    ilv = 0;
    for (int n = 0; n < 4; n++) begin
      rd1(blk + AW'(offs(st, n, il)), d, v);
      chk(tag, d, pat(seed + n));
    end
  endtask

  task automatic t_deselect();
    logic [DW-1:0] d; logic v;
    wr1(6'd40, pat(40), 4'h0);
    for (int c = 0; c < 3; c++) begin
      ld(1, 4'h0, 6'd40);
      if (c == 0) cs1_n = 1; else if (c == 1) cs2 = 0; else cs3_n = 1;
      tick(); nop(); tick(); wdata = '0; tick();
      chk("R8 deselected write no valid", DW'(rvalid), '0);
      wdata = '1;
    end
    rd1(6'd40, d, v);
    chk("R8 deselected writes ignored", d, pat(40));
    ld(0, 4'hF, 6'd40); cs2 = 0; tick();
    set_sel(); adv = 1; we_n = 1; tick();
    nop(); tick();
    chk("R8 deselected read no valid", DW'(rvalid), '0);
    tick();
    chk("R8 continued deselect no valid", DW'(rvalid), '0);
  endtask

  task automatic t_cke();
    logic [DW-1:0] d; logic v;
    wr1(6'd30, pat(30), 4'h0);
    ld(0, 4'hF, 6'd30); tick();
    cke_n = 1; ld(1, 4'h0, 6'd30); wdata = '0; tick(); tick(); tick();
    chk("R9 frozen no valid", DW'(rvalid), '0);
    cke_n = 0; nop(); wdata = '1; tick(); tick();
    chk("R9 read after resume valid", DW'(rvalid), 1);
    chk("R9 read after resume data", rdata, pat(30));
    cke_n = 1; tick(); tick();
    chk("R9 valid held while frozen", DW'(rvalid), 1);
    chk("R9 data held while frozen", rdata, pat(30));
    cke_n = 0; tick();
    chk("R9 valid drops after resume", DW'(rvalid), '0);
    rd1(6'd30, d, v);
    chk("R9 frozen write ignored", d, pat(30));
  endtask

  task automatic t_oe();
    ld(0, 4'hF, 6'd2); tick(); nop(); tick(); tick();
    oe_n = 1; #1;
    chk("R11 oe high blanks valid", DW'(rvalid), '0);
    chk("R11 oe high blanks data", rdata, '0);
    oe_n = 0; #1;
    chk("R11 oe low restores data", rdata, pat(2));
    tick();
  endtask

  task automatic t_sleep();
    logic [DW-1:0] d; logic v;
    wr1(6'd31, pat(31), 4'h0);
    ld(0, 4'hF, 6'd31); tick(); nop(); tick(); tick();
    slp = 1; #1;
    chk("R10 sleep blanks valid", DW'(rvalid), '0);
    chk("R10 sleep blanks data", rdata, '0);
    ld(1, 4'h0, 6'd31); wdata = '0; tick(); tick(); tick();
    slp = 0; nop(); wdata = '1; #1;
    chk("R10 pipeline held across sleep", rdata, pat(31));
    tick();
    rd1(6'd31, d, v);
    chk("R10 write during sleep ignored", d, pat(31));
  endtask

  initial begin : main
    rst_n = 0; cke_n = 0; ilv = 0; oe_n = 0; slp = 0; wdata = '0; addr = '0;
    nop();
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    t_reset();
    t_latency();
    t_turnaround();
    t_bytes();
    burst_rd("R6 linear burst read", 6'd16, 2'd1, 1'b0, 1'b0);
    burst_rd("R7 interleaved burst read, mode toggled", 6'd20, 2'd1, 1'b1, 1'b0);
    burst_wr("R7 interleaved burst write", 6'd24, 2'd3, 1'b1, 200);
    burst_wr("R5 R6 linear burst write", 6'd44, 2'd3, 1'b0, 300);
    t_deselect();
    t_cke();
    t_oe();
    t_sleep();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung, expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule